// File: doc/BRIEF.md
# MSI capture controller

This block turns message-signalled interrupts into pending bits that software can read. Every write that arrives on the inbound port is compared with a 64-bit match address held in two programmable 32-bit words. On a hit, the low eight data bits give a vector number from 0 to 255. Vector v belongs to bank v>>5 and sits at bit v&31 of that bank. The bit is set only if software has enabled that vector. Writes that miss the address, or that name a disabled vector, are dropped without trace.

Software works through a small word-addressed register port. The two match words sit at byte offsets 0x00 (low) and 0x04 (high). The banks start at 0x10 and are spaced 12 bytes apart. Within a bank, the enable word is at +0, the mask word at +4 and the status word at +8. A status bit is pending when it is set and its mask bit is clear. The single `irq` output is the registered OR of every pending bit across all banks. Software services a vector by reading the status word and writing ones back to clear the bits it has handled.

The inbound port is a valid/ready stream. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while reset is applied and high at every later cycle, so an upstream source never stalls outside reset. A source may hold `in_valid` high for any number of cycles, and each cycle with both signals high counts as one separate write.

Top module: `msi_capture`

## Requirements
- R1: After reset every enable word reads 0x00000000, every mask word reads 0xFFFFFFFF, every status word reads 0, both match words read 0, and `irq` is 0.
- R2: The match words at byte offsets 0x00 (low) and 0x04 (high) read back what was written. Bank k starts at offset 0x10+12*k, with enable at +0 and mask at +4, and these also read back what was written.
- R3: An accepted inbound write whose 64-bit address equals {high, low} match words sets status bit v&31 of bank v>>5, where v is data bits [7:0], provided that vector's enable bit is 1. Data bits above bit 7 are ignored.
- R4: An accepted inbound write whose address differs from the match words in either half changes no status bit.
- R5: A matching inbound write naming a vector whose enable bit is 0 changes no status bit.
- R6: Writing the status word (offset +8) clears each bit written as one and leaves bits written as zero unchanged.
- R7: `irq` equals the OR over all banks of (status AND NOT mask) as it stood one clock earlier.
- R8: When an inbound set and a status clear hit the same bit in the same cycle, the bit ends up set.
- R9: Register writes to unmapped offsets (0x08, 0x0C, or at and beyond 0x10+12*NUM_BANKS) change nothing, and reads of these offsets return 0.
- R10: `in_ready` is 0 while `rst_n` is low and 1 from the first clock edge after reset is released.
- R11: `reg_rdata` holds the addressed word, and `reg_rvalid` is 1, in the cycle after the cycle in which `reg_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| in_valid | input | 1 | Inbound write valid |
| in_ready | output | 1 | Inbound write ready |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: eight banks of 32 vectors and an 8-bit register offset. These defaults make vector 255 (bank 7, bit 31) reachable. They also make the first unmapped offset past the last bank, 0x70, reachable, which is the edge that R9 covers. A mirror model follows random enable, mask, clear and inbound traffic, and it compares `irq` after every operation. Directed cases cover a set and a clear on the same bit in the same cycle, and mismatches in each half of the match address.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  typedef enum logic [1:0] {
    FLD_ENABLE = 2'd0,
    FLD_MASK   = 2'd1,
    FLD_STATUS = 2'd2,
    FLD_NONE   = 2'd3
  } bank_fld_e;

  localparam int unsigned OFS_MATCH_LO  = 0;
  localparam int unsigned OFS_MATCH_HI  = 4;
  localparam int unsigned OFS_BANK_BASE = 16;
  localparam int unsigned BANK_STRIDE   = 12;
endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned REG_AW    = 8
) (
  input  logic [REG_AW-1:0]    addr,
  output logic                 lo_sel,
  output logic                 hi_sel,
  output logic [NUM_BANKS-1:0] bank_sel,
  output bank_fld_e            fld
);
  logic [REG_AW-1:0] rel [NUM_BANKS];

  assign lo_sel = (addr == REG_AW'(OFS_MATCH_LO));
  assign hi_sel = (addr == REG_AW'(OFS_MATCH_HI));

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank_dec
    localparam int unsigned BASE = OFS_BANK_BASE + BANK_STRIDE * k;
    assign rel[k]      = addr - REG_AW'(BASE);
    assign bank_sel[k] = (addr >= REG_AW'(BASE)) &&
                         (addr < REG_AW'(BASE + BANK_STRIDE)) &&
                         (addr[1:0] == 2'b00);
  end

  always_comb begin
    fld = FLD_NONE;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (bank_sel[k]) fld = bank_fld_e'(rel[k][3:2]);
    end
  end
endmodule

// File: rtl/msi_cap_match.sv
module msi_cap_match #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 32,
  localparam int unsigned VEC_W    = $clog2(NUM_BANKS * BANK_W),
  localparam int unsigned BIT_W    = $clog2(BANK_W),
  localparam int unsigned BIDX_W   = (VEC_W > BIT_W) ? VEC_W - BIT_W : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lo_wr,
  input  logic                 hi_wr,
  input  logic [31:0]          wdata,
  input  logic                 in_valid,
  input  logic [63:0]          in_addr,
  input  logic [31:0]          in_data,
  output logic                 in_ready,
  output logic [31:0]          match_lo,
  output logic [31:0]          match_hi,
  output logic [NUM_BANKS-1:0] set_en,
  output logic [BIT_W-1:0]     set_bit
);
  logic             fire;
  logic             hit;
  logic [VEC_W-1:0] vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      match_lo <= '0;
      match_hi <= '0;
    end else begin
      in_ready <= 1'b1;
      if (lo_wr) match_lo <= wdata;
      if (hi_wr) match_hi <= wdata;
    end
  end

  assign fire    = in_valid && in_ready;
  assign hit     = (in_addr == {match_hi, match_lo});
  assign vec     = in_data[VEC_W-1:0];
  assign set_bit = vec[BIT_W-1:0];

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_route
    assign set_en[k] = fire && hit && (vec[VEC_W-1:BIT_W] == BIDX_W'(k));
  end
endmodule

// File: rtl/msi_cap_bank.sv
module msi_cap_bank
  import msi_cap_pkg::*;
#(
  parameter int unsigned BANK_W = 32,
  localparam int unsigned BIT_W = $clog2(BANK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  bank_fld_e         fld,
  input  logic [BANK_W-1:0] wdata,
  input  logic              set_en,
  input  logic [BIT_W-1:0]  set_bit,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] stat_q
);
  logic [BANK_W-1:0] clr_vec;
  logic [BANK_W-1:0] set_vec;

  always_comb begin
    clr_vec = (wr_en && fld == FLD_STATUS) ? wdata : '0;
    set_vec = set_en ? ((BANK_W'(1) << set_bit) & en_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (wr_en && fld == FLD_ENABLE) en_q   <= wdata;
      if (wr_en && fld == FLD_MASK)   mask_q <= wdata;
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end
endmodule

// File: rtl/msi_cap_irq.sv
module msi_cap_irq #(
  parameter int unsigned N = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pending,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pending;
  end
endmodule

// File: rtl/msi_capture.sv
module msi_capture
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned REG_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_addr,
  input  logic [31:0]       in_data,
  output logic              irq
);
  localparam int unsigned NVEC  = NUM_BANKS * BANK_W;
  localparam int unsigned BIT_W = $clog2(BANK_W);

  logic                 lo_sel, hi_sel;
  logic [NUM_BANKS-1:0] bank_sel;
  bank_fld_e            fld;
  logic [31:0]          match_lo, match_hi;
  logic [NUM_BANKS-1:0] set_en;
  logic [BIT_W-1:0]     set_bit;
  logic [NVEC-1:0]      en_flat, mask_flat, stat_flat;
  logic [31:0]          rd_mux;

  msi_cap_decode #(.NUM_BANKS(NUM_BANKS), .REG_AW(REG_AW)) u_dec (
    .addr(reg_addr), .lo_sel(lo_sel), .hi_sel(hi_sel),
    .bank_sel(bank_sel), .fld(fld)
  );

  msi_cap_match #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .lo_wr(reg_wr && lo_sel), .hi_wr(reg_wr && hi_sel), .wdata(reg_wdata),
    .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .in_ready(in_ready), .match_lo(match_lo), .match_hi(match_hi),
    .set_en(set_en), .set_bit(set_bit)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    msi_cap_bank #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && bank_sel[k]), .fld(fld),
      .wdata(reg_wdata[BANK_W-1:0]),
      .set_en(set_en[k]), .set_bit(set_bit),
      .en_q(en_flat[k*BANK_W +: BANK_W]),
      .mask_q(mask_flat[k*BANK_W +: BANK_W]),
      .stat_q(stat_flat[k*BANK_W +: BANK_W])
    );
  end

  msi_cap_irq #(.N(NVEC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .pending(stat_flat & ~mask_flat), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (lo_sel) rd_mux = match_lo;
    if (hi_sel) rd_mux = match_hi;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (bank_sel[k]) begin
        case (fld)
          FLD_ENABLE: rd_mux = 32'(en_flat[k*BANK_W +: BANK_W]);
          FLD_MASK:   rd_mux = 32'(mask_flat[k*BANK_W +: BANK_W]);
          FLD_STATUS: rd_mux = 32'(stat_flat[k*BANK_W +: BANK_W]);
          default:    rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int unsigned N = 256,
  localparam int unsigned VW = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic         in_valid,
  input logic         in_ready,
  input logic [63:0]  in_addr,
  input logic [31:0]  in_data,
  input logic [31:0]  match_lo,
  input logic [31:0]  match_hi,
  input logic [N-1:0] en_flat,
  input logic [N-1:0] mask_flat,
  input logic [N-1:0] stat_flat,
  input logic         irq
);
  // R3
  set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat_flat & ~$past(stat_flat)) <= 1);

  // R4 and R5
  drop_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready &&
     !((in_addr == {match_hi, match_lo}) && en_flat[in_data[VW-1:0]]))
    |=> ((stat_flat & ~$past(stat_flat)) == '0));

  // R6
  clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_flat) & ~stat_flat) != '0) |-> $past(reg_wr));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((stat_flat & ~mask_flat) != '0));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past((stat_flat & ~mask_flat) == '0));

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

bind msi_capture msi_capture_chk #(.N(NUM_BANKS * BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
  .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
  .in_data(in_data), .match_lo(match_lo), .match_hi(match_hi),
  .en_flat(en_flat), .mask_flat(mask_flat), .stat_flat(stat_flat),
  .irq(irq)
);

// File: tb/msi_capture_tb.sv
module msi_capture_tb;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic        in_valid, in_ready;
  logic [63:0] in_addr;
  logic [31:0] in_data;
  logic        irq;

  always #4 clk = ~clk;

  msi_capture u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] m_en [NB];
  logic [31:0] m_mask [NB];
  logic [31:0] m_st [NB];
  logic [63:0] m_match;

  function automatic logic [7:0] fa(int k, int f);
    return 8'(16 + 12 * k + 4 * f);
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int k = 0; k < NB; k++) r |= |(m_st[k] & ~m_mask[k]);
    return r;
  endfunction

  function automatic void model_wr(logic [7:0] a, logic [31:0] d);
    int ai = int'(a);
    if (ai == 0) m_match[31:0] = d;
    else if (ai == 4) m_match[63:32] = d;
    else if (ai >= 16 && ai < 16 + 12 * NB && ai % 4 == 0) begin
      int k = (ai - 16) / 12;
      int f = ((ai - 16) % 12) / 4;
      if (f == 0) m_en[k] = d;
      else if (f == 1) m_mask[k] = d;
      else m_st[k] &= ~d;
    end
  endfunction

  function automatic logic [31:0] model_rd(logic [7:0] a);
    int ai = int'(a);
    if (ai == 0) return m_match[31:0];
    if (ai == 4) return m_match[63:32];
    if (ai >= 16 && ai < 16 + 12 * NB && ai % 4 == 0) begin
      int k = (ai - 16) / 12;
      int f = ((ai - 16) % 12) / 4;
      if (f == 0) return m_en[k];
      if (f == 1) return m_mask[k];
      return m_st[k];
    end
    return 32'h0;
  endfunction

  function automatic void model_push(logic [63:0] a, logic [31:0] d);
    int v = int'(d[7:0]);
    if (a == m_match && m_en[v / 32][v % 32]) m_st[v / 32][v % 32] = 1'b1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic check_rd(string req, logic [7:0] a, logic [31:0] exp);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  task automatic do_push(logic [63:0] a, logic [31:0] d);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    model_push(a, d);
  endtask

  task automatic check_irq(string req);
    @(negedge clk);
    check(req, {63'h0, irq}, {63'h0, exp_irq()});
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; in_valid = 1'b0; in_addr = '0; in_data = '0;
    m_match = '0;
    for (int k = 0; k < NB; k++) begin
      m_en[k] = '0; m_mask[k] = '1; m_st[k] = '0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 ready in reset", {63'h0, in_ready}, 64'h0);
    check("R1 irq reset", {63'h0, irq}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", {63'h0, in_ready}, 64'h1);

    // R11: read latency and valid flag
    reg_rd = 1'b1; reg_addr = fa(0, 1);
    @(negedge clk);
    reg_rd = 1'b0;
    check("R11 rvalid", {63'h0, reg_rvalid}, 64'h1);
    check("R11 rdata", {32'h0, reg_rdata}, 64'hFFFF_FFFF);

    // R1: reset contents
    check_rd("R1 match lo", 8'h00, 32'h0);
    check_rd("R1 match hi", 8'h04, 32'h0);
    check_rd("R1 enable b0", fa(0, 0), 32'h0);
    check_rd("R1 mask b7", fa(7, 1), 32'hFFFF_FFFF);
    check_rd("R1 status b7", fa(7, 2), 32'h0);

    // R2: layout and read-back
    do_wr(8'h00, 32'hFEE0_1000);
    do_wr(8'h04, 32'h0000_0000);
    check_rd("R2 match lo", 8'h00, 32'hFEE0_1000);
    do_wr(fa(3, 0), 32'hA5A5_0F0F);
    check_rd("R2 enable b3", fa(3, 0), 32'hA5A5_0F0F);
    do_wr(fa(3, 1), 32'h1234_5678);
    check_rd("R2 mask b3", fa(3, 1), 32'h1234_5678);

    // R9: unmapped offsets
    do_wr(8'h08, 32'hDEAD_BEEF);
    do_wr(8'h70, 32'hFFFF_FFFF);
    check_rd("R9 read 0x08", 8'h08, 32'h0);
    check_rd("R9 read 0x70", 8'h70, 32'h0);
    check_rd("R9 b7 enable untouched", fa(7, 0), 32'h0);
    check_rd("R9 match lo untouched", 8'h00, 32'hFEE0_1000);

    // R3: enabled vector sets its bit; masked so irq stays low
    do_wr(fa(0, 0), 32'h0000_00A0);
    do_push(m_match, 32'h0000_0005);
    check_rd("R3 status b0 bit5", fa(0, 2), 32'h0000_0020);
    check_irq("R7 masked pending");
    do_wr(fa(0, 1), 32'hFFFF_FFDF);
    check_irq("R7 unmasked pending");
    check("R7 irq high", {63'h0, irq}, 64'h1);

    // R5: disabled vector dropped
    do_push(m_match, 32'h0000_0006);
    check_rd("R5 disabled vec", fa(0, 2), 32'h0000_0020);

    // R4: address mismatch in each half
    do_push({32'h0000_0001, 32'hFEE0_1000}, 32'h0000_0007);
    do_push({32'h0000_0000, 32'hFEE0_1004}, 32'h0000_0007);
    check_rd("R4 mismatch", fa(0, 2), 32'h0000_0020);

    // R3: top vector, upper data bits ignored
    do_wr(fa(7, 0), 32'h8000_0000);
    do_push(m_match, 32'hABCD_12FF);
    check_rd("R3 vec255", fa(7, 2), 32'h8000_0000);

    // R6: W1C behaviour
    do_wr(fa(0, 2), 32'h0000_0000);
    check_rd("R6 zero write", fa(0, 2), 32'h0000_0020);
    do_wr(fa(0, 2), 32'h0000_0020);
    check_rd("R6 one clears", fa(0, 2), 32'h0);
    check_irq("R7 after clear");

    // R8: set and clear on the same bit in one cycle
    do_push(m_match, 32'h0000_0005);
    reg_wr = 1'b1; reg_addr = fa(0, 2); reg_wdata = 32'h0000_0020;
    in_valid = 1'b1; in_addr = m_match; in_data = 32'h0000_0005;
    @(negedge clk);
    reg_wr = 1'b0; in_valid = 1'b0;
    model_wr(fa(0, 2), 32'h0000_0020);
    model_push(m_match, 32'h0000_0005);
    check_rd("R8 set wins", fa(0, 2), 32'h0000_0020);
    check_irq("R7 after collision");

    // Random mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom_range(0, 5));
      int k = int'($urandom_range(0, NB - 1));
      case (op)
        0: do_wr(fa(k, 0), $urandom());
        1: do_wr(fa(k, 1), $urandom() | $urandom());
        2: do_wr(fa(k, 2), $urandom() & $urandom());
        3, 4: begin
          logic [63:0] a = ($urandom_range(0, 3) != 0) ? m_match
                           : {m_match[63:32], m_match[31:0] ^ 32'h4};
          do_push(a, $urandom());
        end
        default: begin
          logic [7:0] a = fa(k, int'($urandom_range(0, 2)));
          check_rd("R3 R6 random readback", a, model_rd(a));
        end
      endcase
      check_irq("R7 random");
    end

    for (int k = 0; k < NB; k++) begin
      check_rd("R3 final status", fa(k, 2), m_st[k]);
      check_rd("R2 final enable", fa(k, 0), m_en[k]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule